// File: doc/BRIEF.md
# Instruction Decode Classifier

This block takes one 32-bit word of a classic load/store RISC instruction set and sorts it into a single operation class. It also breaks the word into its bit fields. Three opcodes open secondary decode spaces. Two of them are indexed by the low six function bits, and one is indexed by the 5-bit rt field. The block folds all of these into one 10-bit tagged operation code, so that later stages can switch on a single value.

Beside the class, the block reports why a word cannot execute: a reserved encoding, a system call, a breakpoint, or an access to an absent coprocessor together with that coprocessor's number. Words that have no architectural effect come out as the no-op class. These include barriers, cache hints, prefetches and ALU operations that write the zero register. Execution, register reads and memory access belong to other blocks.

A parameter selects whether the outputs are registered. With the register, which is the default, every output reflects the word sampled at the previous rising clock edge.

Top module: `insn_classify`

## Requirements
- R1: Fields come out as op=[31:26], rs=[25:21], rt=[20:16], rd=[15:11], sa=[10:6] and funct=[5:0]. imm_o is bits [15:0] sign-extended to 32 bits.
- R2: tag_o is 0x100|funct when op=0x00, 0x200|funct when op=0x1C, and 0x300|rt when op=0x01. For any other opcode it is the opcode zero-extended.
- R3: class_o is one-hot with this bit order: 0 ALU-immediate, 1 ALU-register, 2 multiply/divide, 3 HI/LO move, 4 branch/jump, 5 trap, 6 load/store, 7 coprocessor-0, 8 no-op, 9 exception. Bit 9 is set exactly when cause_o is not 0.
- R4: Primary opcodes decode as follows. 0x02–0x07 are branch/jump. 0x08–0x0F are ALU-immediate. 0x20–0x26, 0x28–0x2B and 0x2E are load/store, even when rt=0. Opcode 0x10 is coprocessor-0 when rs is 0x00 or 0x04, or when rs[4]=1 and funct is one of 0x01, 0x02, 0x06, 0x08, 0x18, 0x1F or 0x20.
- R5: op=0x00 decodes by funct:
  - 0x00, 0x02 and 0x03 are ALU-immediate.
  - 0x04, 0x06, 0x07, 0x0A, 0x0B, 0x20–0x27, 0x2A and 0x2B are ALU-register.
  - 0x18–0x1B are multiply/divide.
  - 0x10–0x13 are HI/LO move.
  - 0x08 and 0x09 are branch/jump.
  - 0x30–0x34 and 0x36 are trap.
- R6: op=0x1C decodes by funct. 0x00, 0x01, 0x04 and 0x05 are multiply/divide. 0x02, 0x20 and 0x21 are ALU-register.
- R7: op=0x01 decodes by rt. 0x00–0x03 and 0x10–0x13 are branch. 0x08–0x0C and 0x0E are trap.
- R8: op=0x00 with funct 0x0C gives cause 2 (syscall). op=0x00 with funct 0x0D, and op=0x1C with funct 0x3F, give cause 3 (break).
- R9: op=0x00 with funct 0x0F, and opcodes 0x2F and 0x33, decode as no-op with cause 0.
- R10: Cause 4 (coprocessor unusable) is raised with these coprocessor numbers:
  - cop 1 for opcodes 0x11, 0x31, 0x35, 0x39 and 0x3D, and for op=0x00 with funct 0x01.
  - cop 2 for opcodes 0x12, 0x32, 0x36, 0x3A and 0x3E.
  - cop 3 for opcode 0x13.
- R11: Every encoding not listed in R4–R10 decodes as exception class with cause 1 (reserved).
- R12: When the destination is r0, an ALU operation becomes a no-op. The destination is rt for opcodes 0x09–0x0F and rd for the register forms and shifts. MFHI and MFLO (funct 0x10 and 0x12) follow the same rule. ADD (funct 0x20), SUB (funct 0x22) and opcode 0x08 keep their ALU class.
- R13: With OUT_REG=1, outputs follow insn_i one clock later. While rst_ni is low, all outputs are zero except class_o, which shows no-op.
- R14: cop_num_o is 0 whenever cause_o is not 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| op_o | output | 6 | Primary opcode field |
| rs_o | output | 5 | rs field |
| rt_o | output | 5 | rt field |
| rd_o | output | 5 | rd field |
| sa_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function field |
| imm_o | output | 32 | Sign-extended immediate |
| tag_o | output | 10 | Tagged operation code |
| class_o | output | 10 | One-hot operation class |
| cause_o | output | 3 | 0 none, 1 reserved, 2 syscall, 3 break, 4 coprocessor unusable |
| cop_num_o | output | 2 | Unusable coprocessor number |

## Verification
The timed properties assume a fully known insn_i at every rising edge after reset. They also assume that the output register is enabled, since they compare an output with the word sampled one clock earlier. The stimulus changes insn_i only on falling edges and never drives unknown bits. It starts instruction traffic only after reset is released, so every word sampled by the properties is one the bench also scores. The sweeps cover:
- every primary opcode, in two field patterns;
- every function code of both function-indexed spaces, with rd zero and nonzero;
- every rt code of the rt-indexed space;
- the coprocessor-0 space over several rs values.

// File: rtl/insn_pkg.sv
`timescale 1ns/1ps
package insn_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;
  localparam int TAG_W  = 10;
  localparam int NCLASS = 10;
  localparam int CAUSE_W = 3;
  localparam int COP_W  = 2;

  localparam logic [OP_W-1:0] OP_SPC  = 6'h00;
  localparam logic [OP_W-1:0] OP_RIMM = 6'h01;
  localparam logic [OP_W-1:0] OP_CP0  = 6'h10;
  localparam logic [OP_W-1:0] OP_SPC2 = 6'h1C;

  typedef enum logic [3:0] {
    CL_ALU_IMM = 4'd0, CL_ALU_REG = 4'd1, CL_MULDIV = 4'd2, CL_HILO = 4'd3,
    CL_BRANCH  = 4'd4, CL_TRAP    = 4'd5, CL_LDST   = 4'd6, CL_CP0  = 4'd7,
    CL_NOP     = 4'd8, CL_EXC     = 4'd9
  } cls_e;

  typedef enum logic [CAUSE_W-1:0] {
    CS_NONE = 3'd0, CS_RSVD = 3'd1, CS_SYSCALL = 3'd2, CS_BREAK = 3'd3, CS_COPU = 3'd4
  } cause_e;

  typedef struct packed {
    cls_e             cls;
    cause_e           cause;
    logic [COP_W-1:0] cop;
  } dec_t;

  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [NCLASS-1:0]  cls_oh;
    logic [CAUSE_W-1:0] cause;
    logic [COP_W-1:0]   cop;
    logic [OP_W-1:0]    op;
    logic [REG_W-1:0]   rs;
    logic [REG_W-1:0]   rt;
    logic [REG_W-1:0]   rd;
    logic [REG_W-1:0]   sa;
    logic [OP_W-1:0]    funct;
    logic [WORD_W-1:0]  imm;
  } out_t;
endpackage

// File: rtl/insn_fields.sv
`timescale 1ns/1ps
module insn_fields
  import insn_pkg::*;
(
  input  logic [WORD_W-1:0] insn_i,
  output logic [OP_W-1:0]   op_o,
  output logic [REG_W-1:0]  rs_o,
  output logic [REG_W-1:0]  rt_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  sa_o,
  output logic [OP_W-1:0]   funct_o,
  output logic [WORD_W-1:0] imm_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int FN_PAD = TAG_W - 2 - OP_W;
  localparam int RT_PAD = TAG_W - 2 - REG_W;

  assign op_o    = insn_i[31:26];
  assign rs_o    = insn_i[25:21];
  assign rt_o    = insn_i[20:16];
  assign rd_o    = insn_i[15:11];
  assign sa_o    = insn_i[10:6];
  assign funct_o = insn_i[5:0];
  assign imm_o   = {{(WORD_W-IMM_W){insn_i[IMM_W-1]}}, insn_i[IMM_W-1:0]};

  // secondary spaces get a 2-bit space tag above the sub-code
  always_comb begin
    case (op_o)
      OP_SPC:  tag_o = {2'd1, {FN_PAD{1'b0}}, funct_o};
      OP_SPC2: tag_o = {2'd2, {FN_PAD{1'b0}}, funct_o};
      OP_RIMM: tag_o = {2'd3, {RT_PAD{1'b0}}, rt_o};
      default: tag_o = {{(TAG_W-OP_W){1'b0}}, op_o};
    endcase
  end
endmodule

// File: rtl/insn_decode.sv
`timescale 1ns/1ps
module insn_decode
  import insn_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [OP_W-1:0]  funct_i,
  output dec_t             dec_o
);
  function automatic dec_t mk(input cls_e c, input cause_e e, input logic [COP_W-1:0] n);
    dec_t d;
    d.cls   = c;
    d.cause = e;
    d.cop   = n;
    return d;
  endfunction

  function automatic dec_t ok(input cls_e c);
    return mk(c, CS_NONE, '0);
  endfunction

  function automatic dec_t dec_spc(input logic [OP_W-1:0] f, input logic rd0);
    dec_t d;
    d = mk(CL_EXC, CS_RSVD, '0);
    case (f) inside
      6'h00, 6'h02, 6'h03:                   d = rd0 ? ok(CL_NOP) : ok(CL_ALU_IMM);
      6'h04, 6'h06, 6'h07, 6'h0A, 6'h0B,
      6'h21, 6'h23, [6'h24:6'h27],
      6'h2A, 6'h2B:                          d = rd0 ? ok(CL_NOP) : ok(CL_ALU_REG);
      6'h20, 6'h22:                          d = ok(CL_ALU_REG); // overflow must still trap
      [6'h18:6'h1B]:                         d = ok(CL_MULDIV);
      6'h10, 6'h12:                          d = rd0 ? ok(CL_NOP) : ok(CL_HILO);
      6'h11, 6'h13:                          d = ok(CL_HILO);
      6'h08, 6'h09:                          d = ok(CL_BRANCH);
      [6'h30:6'h34], 6'h36:                  d = ok(CL_TRAP);
      6'h0C:                                 d = mk(CL_EXC, CS_SYSCALL, '0);
      6'h0D:                                 d = mk(CL_EXC, CS_BREAK, '0);
      6'h0F:                                 d = ok(CL_NOP);
      6'h01:                                 d = mk(CL_EXC, CS_COPU, 2'd1);
      default:                               d = mk(CL_EXC, CS_RSVD, '0);
    endcase
    return d;
  endfunction

  function automatic dec_t dec_spc2(input logic [OP_W-1:0] f, input logic rd0);
    dec_t d;
    case (f) inside
      6'h00, 6'h01, 6'h04, 6'h05: d = ok(CL_MULDIV);
      6'h02, 6'h20, 6'h21:        d = rd0 ? ok(CL_NOP) : ok(CL_ALU_REG);
      6'h3F:                      d = mk(CL_EXC, CS_BREAK, '0);
      default:                    d = mk(CL_EXC, CS_RSVD, '0);
    endcase
    return d;
  endfunction

  function automatic dec_t dec_rimm(input logic [REG_W-1:0] r);
    dec_t d;
    case (r) inside
      [5'h00:5'h03], [5'h10:5'h13]: d = ok(CL_BRANCH);
      [5'h08:5'h0C], 5'h0E:         d = ok(CL_TRAP);
      default:                      d = mk(CL_EXC, CS_RSVD, '0);
    endcase
    return d;
  endfunction

  function automatic dec_t dec_cp0(input logic [REG_W-1:0] s, input logic [OP_W-1:0] f);
    dec_t d;
    d = mk(CL_EXC, CS_RSVD, '0);
    if (s == 5'h00 || s == 5'h04) d = ok(CL_CP0);
    else if (s[REG_W-1] && (f inside {6'h01, 6'h02, 6'h06, 6'h08, 6'h18, 6'h1F, 6'h20}))
      d = ok(CL_CP0);
    return d;
  endfunction

  always_comb begin
    case (op_i) inside
      OP_SPC:                          dec_o = dec_spc(funct_i, rd_i == '0);
      OP_SPC2:                         dec_o = dec_spc2(funct_i, rd_i == '0);
      OP_RIMM:                         dec_o = dec_rimm(rt_i);
      OP_CP0:                          dec_o = dec_cp0(rs_i, funct_i);
      [6'h02:6'h07]:                   dec_o = ok(CL_BRANCH);
      6'h08:                           dec_o = ok(CL_ALU_IMM);
      [6'h09:6'h0F]:                   dec_o = (rt_i == '0) ? ok(CL_NOP) : ok(CL_ALU_IMM);
      [6'h20:6'h26], [6'h28:6'h2B],
      6'h2E:                           dec_o = ok(CL_LDST);
      6'h2F, 6'h33:                    dec_o = ok(CL_NOP);
      6'h11, 6'h31, 6'h35, 6'h39, 6'h3D: dec_o = mk(CL_EXC, CS_COPU, 2'd1);
      6'h12, 6'h32, 6'h36, 6'h3A, 6'h3E: dec_o = mk(CL_EXC, CS_COPU, 2'd2);
      6'h13:                           dec_o = mk(CL_EXC, CS_COPU, 2'd3);
      default:                         dec_o = mk(CL_EXC, CS_RSVD, '0);
    endcase
  end
endmodule

// File: rtl/insn_out_stage.sv
`timescale 1ns/1ps
module insn_out_stage #(
  parameter int           W   = 8,
  parameter bit           REG = 1'b1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= RST;
      else         q_o <= d_i;
    end

    AST_STAGE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> q_o == $past(d_i)); // R13
  end else begin : g_bypass
    assign q_o = d_i;
  end
endmodule

// File: rtl/insn_classify.sv
`timescale 1ns/1ps
module insn_classify
  import insn_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   insn_i,
  output logic [OP_W-1:0]     op_o,
  output logic [REG_W-1:0]    rs_o,
  output logic [REG_W-1:0]    rt_o,
  output logic [REG_W-1:0]    rd_o,
  output logic [REG_W-1:0]    sa_o,
  output logic [OP_W-1:0]     funct_o,
  output logic [WORD_W-1:0]   imm_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [NCLASS-1:0]   class_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [COP_W-1:0]    cop_num_o
);
  localparam int OUT_W = $bits(out_t);

  function automatic out_t rst_val();
    out_t r;
    r = '0;
    r.cls_oh[CL_NOP] = 1'b1;
    return r;
  endfunction
  localparam out_t OUT_RST = rst_val();

  logic [OP_W-1:0]   f_op, f_funct;
  logic [REG_W-1:0]  f_rs, f_rt, f_rd, f_sa;
  logic [WORD_W-1:0] f_imm;
  logic [TAG_W-1:0]  f_tag;
  dec_t              dec;
  logic [NCLASS-1:0] cls_oh;
  out_t              nxt, cur;

  insn_fields u_fields (
    .insn_i (insn_i), .op_o (f_op), .rs_o (f_rs), .rt_o (f_rt), .rd_o (f_rd),
    .sa_o (f_sa), .funct_o (f_funct), .imm_o (f_imm), .tag_o (f_tag)
  );

  insn_decode u_decode (
    .op_i (f_op), .rs_i (f_rs), .rt_i (f_rt), .rd_i (f_rd), .funct_i (f_funct), .dec_o (dec)
  );

  always_comb begin
    cls_oh = '0;
    cls_oh[dec.cls] = 1'b1;
  end

  always_comb begin
    nxt.tag    = f_tag;
    nxt.cls_oh = cls_oh;
    nxt.cause  = dec.cause;
    nxt.cop    = dec.cop;
    nxt.op     = f_op;
    nxt.rs     = f_rs;
    nxt.rt     = f_rt;
    nxt.rd     = f_rd;
    nxt.sa     = f_sa;
    nxt.funct  = f_funct;
    nxt.imm    = f_imm;
  end

  insn_out_stage #(.W(OUT_W), .REG(OUT_REG), .RST(OUT_RST)) u_stage (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (nxt), .q_o (cur)
  );

  assign tag_o     = cur.tag;
  assign class_o   = cur.cls_oh;
  assign cause_o   = cur.cause;
  assign cop_num_o = cur.cop;
  assign op_o      = cur.op;
  assign rs_o      = cur.rs;
  assign rt_o      = cur.rt;
  assign rd_o      = cur.rd;
  assign sa_o      = cur.sa;
  assign funct_o   = cur.funct;
  assign imm_o     = cur.imm;

  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(class_o) == 1); // R3
  AST_EXC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CL_EXC] == (cause_o != CS_NONE)); // R3
  AST_COP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o != CS_COPU |-> cop_num_o == '0); // R14

  if (OUT_REG) begin : g_timed_chk
    AST_SYSCALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      insn_i[31:26] == OP_SPC && insn_i[5:0] == 6'h0C |=> cause_o == CS_SYSCALL); // R8
    AST_RIMM_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      insn_i[31:26] == OP_RIMM |=> tag_o == {2'd3, 3'd0, $past(insn_i[20:16])}); // R2
    AST_LOAD_RT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      insn_i[31:26] == 6'h23 |=> class_o[CL_LDST]); // R4
  end
endmodule

// File: tb/insn_classify_tb_top.sv
`timescale 1ns/1ps
module insn_classify_tb_top;
  localparam int K_ALUI = 0, K_ALUR = 1, K_MD = 2, K_HILO = 3, K_BR = 4,
                 K_TRAP = 5, K_LDST = 6, K_CP0 = 7, K_NOP = 8, K_EXC = 9;
  localparam int C_NONE = 0, C_RSVD = 1, C_SYS = 2, C_BRK = 3, C_COPU = 4;
  localparam int WD_CYC = 20000;

  typedef struct {
    int    cls;
    int    cause;
    int    cop;
    string req;
  } exp_t;

  typedef struct {
    logic [31:0] w;
    exp_t        e;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn = '0;
  logic [5:0]  op_o, funct_o;
  logic [4:0]  rs_o, rt_o, rd_o, sa_o;
  logic [31:0] imm_o;
  logic [9:0]  tag_o, class_o;
  logic [2:0]  cause_o;
  logic [1:0]  cop_num_o;

  int n_chk = 0;
  int n_fail = 0;
  item_t q[$];

  always #4 clk = ~clk;

  insn_classify dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .insn_i (insn),
    .op_o (op_o), .rs_o (rs_o), .rt_o (rt_o), .rd_o (rd_o), .sa_o (sa_o),
    .funct_o (funct_o), .imm_o (imm_o), .tag_o (tag_o), .class_o (class_o),
    .cause_o (cause_o), .cop_num_o (cop_num_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t ex(input int c, input int e, input int n, input string r);
    exp_t x;
    x.cls = c; x.cause = e; x.cop = n; x.req = r;
    return x;
  endfunction

  // reference table built from the requirements
  function automatic exp_t model(input logic [31:0] w);
    logic [5:0] op, f;
    logic [4:0] rs, rt, rd;
    bit rd0;
    exp_t e;
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; f = w[5:0];
    rd0 = (rd == 0);
    e = ex(K_EXC, C_RSVD, 0, "R11");
    if (op == 6'h00) begin
      if (f inside {6'h00, 6'h02, 6'h03})
        e = rd0 ? ex(K_NOP, C_NONE, 0, "R12") : ex(K_ALUI, C_NONE, 0, "R5");
      else if (f inside {6'h04, 6'h06, 6'h07, 6'h0A, 6'h0B, 6'h21, 6'h23, 6'h24,
                         6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B})
        e = rd0 ? ex(K_NOP, C_NONE, 0, "R12") : ex(K_ALUR, C_NONE, 0, "R5");
      else if (f inside {6'h20, 6'h22}) e = ex(K_ALUR, C_NONE, 0, "R12");
      else if (f inside {[6'h18:6'h1B]}) e = ex(K_MD, C_NONE, 0, "R5");
      else if (f inside {6'h10, 6'h12})
        e = rd0 ? ex(K_NOP, C_NONE, 0, "R12") : ex(K_HILO, C_NONE, 0, "R5");
      else if (f inside {6'h11, 6'h13}) e = ex(K_HILO, C_NONE, 0, "R5");
      else if (f inside {6'h08, 6'h09}) e = ex(K_BR, C_NONE, 0, "R5");
      else if (f inside {[6'h30:6'h34], 6'h36}) e = ex(K_TRAP, C_NONE, 0, "R5");
      else if (f == 6'h0C) e = ex(K_EXC, C_SYS, 0, "R8");
      else if (f == 6'h0D) e = ex(K_EXC, C_BRK, 0, "R8");
      else if (f == 6'h0F) e = ex(K_NOP, C_NONE, 0, "R9");
      else if (f == 6'h01) e = ex(K_EXC, C_COPU, 1, "R10");
    end else if (op == 6'h1C) begin
      if (f inside {6'h00, 6'h01, 6'h04, 6'h05}) e = ex(K_MD, C_NONE, 0, "R6");
      else if (f inside {6'h02, 6'h20, 6'h21})
        e = rd0 ? ex(K_NOP, C_NONE, 0, "R12") : ex(K_ALUR, C_NONE, 0, "R6");
      else if (f == 6'h3F) e = ex(K_EXC, C_BRK, 0, "R8");
    end else if (op == 6'h01) begin
      if (rt inside {[5'h00:5'h03], [5'h10:5'h13]}) e = ex(K_BR, C_NONE, 0, "R7");
      else if (rt inside {[5'h08:5'h0C], 5'h0E}) e = ex(K_TRAP, C_NONE, 0, "R7");
    end else if (op == 6'h10) begin
      if (rs == 5'h00 || rs == 5'h04 ||
          (rs[4] && (f inside {6'h01, 6'h02, 6'h06, 6'h08, 6'h18, 6'h1F, 6'h20})))
        e = ex(K_CP0, C_NONE, 0, "R4");
    end else if (op inside {[6'h02:6'h07]}) e = ex(K_BR, C_NONE, 0, "R4");
    else if (op == 6'h08) e = ex(K_ALUI, C_NONE, 0, "R12");
    else if (op inside {[6'h09:6'h0F]})
      e = (rt == 0) ? ex(K_NOP, C_NONE, 0, "R12") : ex(K_ALUI, C_NONE, 0, "R4");
    else if (op inside {[6'h20:6'h26], [6'h28:6'h2B], 6'h2E}) e = ex(K_LDST, C_NONE, 0, "R4");
    else if (op inside {6'h2F, 6'h33}) e = ex(K_NOP, C_NONE, 0, "R9");
    else if (op inside {6'h11, 6'h31, 6'h35, 6'h39, 6'h3D}) e = ex(K_EXC, C_COPU, 1, "R10");
    else if (op inside {6'h12, 6'h32, 6'h36, 6'h3A, 6'h3E}) e = ex(K_EXC, C_COPU, 2, "R10");
    else if (op == 6'h13) e = ex(K_EXC, C_COPU, 3, "R10");
    return e;
  endfunction

  task automatic drive(input logic [31:0] w);
    item_t it;
    @(negedge clk);
    insn = w;
    it.w = w;
    it.e = model(w);
    q.push_back(it);
  endtask

  // monitor: one cycle after the driving edge, outputs carry the word
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [9:0] xtag;
        logic [31:0] w;
        it = q.pop_front();
        w = it.w;
        if (w[31:26] == 6'h00)      xtag = {4'h4, w[5:0]};
        else if (w[31:26] == 6'h1C) xtag = {4'h8, w[5:0]};
        else if (w[31:26] == 6'h01) xtag = {5'h18, w[20:16]};
        else                        xtag = {4'h0, w[31:26]};
        check({op_o, rs_o, rt_o, rd_o, sa_o, funct_o} == w, "R1", "fields",
              {op_o, rs_o, rt_o, rd_o, sa_o, funct_o}, w);
        check(imm_o == {{16{w[15]}}, w[15:0]}, "R1", "imm", imm_o, {{16{w[15]}}, w[15:0]});
        check(tag_o == xtag, "R2", "tag", tag_o, xtag);
        check($countones(class_o) == 1 && class_o[9] == (cause_o != 0), "R3", "onehot",
              class_o, 10'(1) << it.e.cls);
        check(class_o == (10'(1) << it.e.cls), it.e.req, "class", class_o, 10'(1) << it.e.cls);
        check(cause_o == 3'(it.e.cause), it.e.req, "cause", cause_o, it.e.cause);
        check(cop_num_o == 2'(it.e.cop), (it.e.cause == C_COPU) ? "R10" : "R14", "cop",
              cop_num_o, it.e.cop);
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    insn = 32'h8C21_FFFF;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(class_o == 10'h100 && cause_o == 0 && cop_num_o == 0, "R13", "reset class",
          {cause_o, cop_num_o, class_o}, 10'h100);
    check(tag_o == 0 && imm_o == 0 && {op_o, rs_o, rt_o, rd_o, sa_o, funct_o} == 0, "R13",
          "reset fields", {tag_o, imm_o}, 0);
    insn = '0;
    rst_ni = 1'b1;
    @(negedge clk);

    // primary sweep, two field patterns
    for (int op = 0; op < 64; op++) begin
      drive({6'(op), 5'd3, 5'd7, 5'd9, 5'd2, 6'h25});
      drive({6'(op), 5'd4, 5'd0, 16'hFFF0});
    end
    // function-indexed spaces, rd nonzero and zero
    for (int f = 0; f < 64; f++) begin
      drive({6'h00, 5'd1, 5'd2, 5'd5, 5'd1, 6'(f)});
      drive({6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'(f)});
      drive({6'h1C, 5'd6, 5'd8, 5'd5, 5'd0, 6'(f)});
      drive({6'h1C, 5'd6, 5'd8, 5'd0, 5'd0, 6'(f)});
    end
    // rt-indexed space, negative offset
    for (int r = 0; r < 32; r++) drive({6'h01, 5'd9, 5'(r), 16'h8004});
    // coprocessor-0 space
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 64; f++)
        drive({6'h10, (s == 0) ? 5'h00 : (s == 1) ? 5'h04 : (s == 2) ? 5'h08 : 5'h10,
               5'd2, 5'd12, 5'd0, 6'(f)});
    // zero-destination corners: ADD/SUB/ADDI keep class, load rt=0 executes
    drive({6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h20});
    drive({6'h08, 5'd1, 5'd0, 16'h7FFF});
    drive({6'h23, 5'd1, 5'd0, 16'h0004});

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule